// File: doc/BRIEF.md
# UART Receive/Transmit Buffer with Automatic Handshake

This block sits between a host and the serial shifters of a UART. It buffers received bytes and bytes waiting to be sent, each in its own queue. It raises interrupt requests when a queue crosses a programmable threshold. The host pushes bytes for transmission and pops received bytes through byte-wide ports. A single control write sets the two threshold codes, the two automatic handshake enables and a software RTS bit.

On the line side, the receive shifter delivers each finished character with a one-cycle strobe. The transmit shifter takes the next character through a request/acknowledge pair. With automatic RTS on, the block lowers RTS when the receive queue reaches its threshold, and raises it again once the queue has drained past a one-entry hysteresis band. With automatic CTS on, the block withholds the transmit request while CTS is low. Queued bytes wait for CTS to return; none are discarded. A character already acknowledged by the shifter is outside the block and finishes normally.

Top module: `uart_fc_core`

## Requirements
- R1: The receive queue holds 32 bytes in arrival order. `rx_data` always shows the oldest byte, a `rx_pop` pulse removes it, and `rx_level` gives the number of stored bytes. A pop on an empty queue does nothing.
- R2: A `rx_strobe` while `rx_level` is 32 drops the byte and sets `overrun`. `overrun` stays set until a `stat_rd` pulse clears it. When a drop and `stat_rd` fall in the same cycle, `overrun` ends up set.
- R3: `ctrl_wdata[6:5]` selects the receive threshold: 00 = 8, 01 = 16, 10 = 24, 11 = 28. `rx_irq` is high exactly while `rx_level` is at or above that threshold.
- R4: `ctrl_wdata[4:3]` selects the transmit threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 16. `tx_irq` is high exactly while `tx_level` is at or below it. After reset both codes are 00, which gives a receive threshold of 8 and a transmit threshold of 1.
- R5: With `ctrl_wdata[1]` (auto RTS) set, `rts` goes low in the cycle after `rx_level` reaches the receive threshold. It stays low while the level equals threshold minus one, and goes high in the cycle after the level falls to threshold minus two or less.
- R6: With auto RTS clear, `rts` follows `ctrl_wdata[0]` as last written. All control fields reset to 0, so `rts` is low after reset.
- R7: With `ctrl_wdata[2]` (auto CTS) set, `cts` passes through a two-flop synchronizer. While the synchronized value is low, `tx_req` stays low and the transmit queue keeps all its bytes.
- R8: `tx_req` is high when the transmit queue is non-empty and not blocked by R7. `tx_byte` shows the oldest queued byte. A byte leaves the queue only on a cycle with both `tx_req` and `tx_ack` high, and `tx_ack` alone changes nothing.
- R9: The transmit queue holds 32 bytes. A `tx_push` while it is full is ignored and leaves its contents and order unchanged.
- R10: With auto CTS clear, the level of `cts` has no effect on `tx_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_level | output | 6 | Receive queue fill level |
| stat_rd | input | 1 | Status read pulse, clears overrun |
| overrun | output | 1 | Sticky receive drop flag |
| tx_push | input | 1 | Write `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_level | output | 6 | Transmit queue fill level |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 7 | Control fields: rx code, tx code, auto CTS, auto RTS, software RTS |
| rx_irq | output | 1 | Receive threshold request |
| tx_irq | output | 1 | Transmit threshold request |
| rx_strobe | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Byte from the receive shifter |
| tx_req | output | 1 | Byte available and allowed to go |
| tx_byte | output | 8 | Byte offered to the transmit shifter |
| tx_ack | input | 1 | Transmit shifter takes `tx_byte` |
| cts | input | 1 | Clear-to-send from the far end, asynchronous |
| rts | output | 1 | Request-to-send to the far end |

## Verification
The properties assume that all host and shifter inputs are synchronous to `clk`, except `cts`, and that `tx_ack` means something only together with `tx_req`. They also assume that control writes may change the auto bits in any cycle, so the RTS property allows the auto bit to drop right after the threshold is hit. The stimulus drives every input on the falling edge, applies single-cycle strobes, and toggles `cts` only when the synchronizer has several cycles to settle before a check. It also drives cases that the properties cover: acknowledges with no request, pushes into full queues, and a clear that coincides with a drop.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int RTS_HYST   = 1;
    localparam int CTS_SYNC   = 2;
    localparam int CTRL_W     = 7;

    // control word layout, most significant field first
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       auto_cts;
        logic       auto_rts;
        logic       sw_rts;
    } ctrl_word_t;

    typedef struct packed {
        logic auto_cts;
        logic auto_rts;
        logic sw_rts;
    } flow_cfg_t;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_MID  = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_TOP  = 2'b11
    } trig_code_e;

    function automatic int rx_trig_level(input trig_code_e c);
        case (c)
            TRIG_LOW:  return 8;
            TRIG_MID:  return 16;
            TRIG_HIGH: return 24;
            default:   return 28;
        endcase
    endfunction

    function automatic int tx_trig_level(input trig_code_e c);
        case (c)
            TRIG_LOW:  return 1;
            TRIG_MID:  return 4;
            TRIG_HIGH: return 8;
            default:   return 16;
        endcase
    endfunction

endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // fill level never exceeds capacity
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // a queue that is empty and not written stays empty
    assert_empty_pop_R1: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/uart_fc_regs.sv
module uart_fc_regs
    import uart_fc_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output flow_cfg_t         flow,
    output logic [CW-1:0]     rx_trig,
    output logic [CW-1:0]     tx_trig
);
    ctrl_word_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= ctrl_word_t'(wdata);
    end

    assign flow.auto_cts = ctrl_q.auto_cts;
    assign flow.auto_rts = ctrl_q.auto_rts;
    assign flow.sw_rts   = ctrl_q.sw_rts;
    assign rx_trig = CW'(rx_trig_level(trig_code_e'(ctrl_q.rx_code)));
    assign tx_trig = CW'(tx_trig_level(trig_code_e'(ctrl_q.tx_code)));

endmodule

// File: rtl/uart_fc_flow.sv
module uart_fc_flow
    import uart_fc_pkg::*;
#(
    parameter int CW    = 6,
    parameter int HYST  = RTS_HYST,
    parameter int NSYNC = CTS_SYNC
) (
    input  logic          clk,
    input  logic          rst,
    input  flow_cfg_t     flow,
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] rx_trig,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] tx_trig,
    input  logic          cts,
    output logic          rts,
    output logic          tx_req,
    output logic          rx_irq,
    output logic          tx_irq
);
    localparam int EW = CW + 1;

    logic [NSYNC-1:0] cts_sync;
    logic             cts_ok;
    logic             throttle_q, throttle_d;
    logic [EW-1:0]    release_sum;

    // CTS crosses clock domains: shift it through NSYNC flops
    always_ff @(posedge clk) begin
        if (rst) begin
            cts_sync <= '0;
        end else begin
            cts_sync[0] <= cts;
            for (int i = 1; i < NSYNC; i++) cts_sync[i] <= cts_sync[i-1];
        end
    end
    assign cts_ok = cts_sync[NSYNC-1];

    // throttle with a hysteresis band below the receive threshold
    assign release_sum = EW'(rx_level) + EW'(HYST);
    always_comb begin
        throttle_d = throttle_q;
        if (rx_level >= rx_trig)
            throttle_d = 1'b1;
        else if (release_sum < EW'(rx_trig))
            throttle_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) throttle_q <= 1'b0;
        else     throttle_q <= throttle_d;
    end

    assign rts    = flow.auto_rts ? !throttle_q : flow.sw_rts;
    assign tx_req = (tx_level != '0) && (!flow.auto_cts || cts_ok);
    assign rx_irq = (rx_level >= rx_trig);
    assign tx_irq = (tx_level <= tx_trig);

    // reaching the threshold under auto RTS lowers RTS on the next cycle
    assert_rts_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (flow.auto_rts && rx_level >= rx_trig) |=> (!flow.auto_rts || !rts));

    // inside the hysteresis band the throttle does not release
    assert_rts_band_R5: assert property (@(posedge clk) disable iff (rst)
        (throttle_q && release_sum >= EW'(rx_trig)) |=> throttle_q);

endmodule

// File: rtl/uart_fc_core.sv
module uart_fc_core
    import uart_fc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_pop,
    output logic [DW-1:0]              rx_data,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    input  logic                       stat_rd,
    output logic                       overrun,
    input  logic                       tx_push,
    input  logic [DW-1:0]              tx_wdata,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    input  logic                       ctrl_we,
    input  logic [CTRL_W-1:0]          ctrl_wdata,
    output logic                       rx_irq,
    output logic                       tx_irq,
    input  logic                       rx_strobe,
    input  logic [DW-1:0]              rx_byte,
    output logic                       tx_req,
    output logic [DW-1:0]              tx_byte,
    input  logic                       tx_ack,
    input  logic                       cts,
    output logic                       rts
);
    localparam int CW = $clog2(DEPTH + 1);

    flow_cfg_t     flow;
    logic [CW-1:0] rx_trig, tx_trig;
    logic          rx_drop, tx_take;

    assign rx_drop = rx_strobe && (rx_level == CW'(DEPTH));
    assign tx_take = tx_req && tx_ack;

    uart_fc_regs #(.CW(CW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .wdata   (ctrl_wdata),
        .flow    (flow),
        .rx_trig (rx_trig),
        .tx_trig (tx_trig)
    );

    uart_fc_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_strobe),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_data),
        .count (rx_level)
    );

    uart_fc_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_take),
        .rdata (tx_byte),
        .count (tx_level)
    );

    uart_fc_flow #(.CW(CW)) u_flow (
        .clk      (clk),
        .rst      (rst),
        .flow     (flow),
        .rx_level (rx_level),
        .rx_trig  (rx_trig),
        .tx_level (tx_level),
        .tx_trig  (tx_trig),
        .cts      (cts),
        .rts      (rts),
        .tx_req   (tx_req),
        .rx_irq   (rx_irq),
        .tx_irq   (tx_irq)
    );

    // sticky drop flag; a new drop outranks a clearing read
    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (rx_drop) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    assert_rx_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_level == CW'(DEPTH) && !rx_pop)
            |=> (rx_level == CW'(DEPTH) && overrun));

    assert_overrun_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_rd) |=> overrun);

    // without a request the transmit queue never shrinks
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> (tx_level >= $past(tx_level)));

    assert_tx_full_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_level == CW'(DEPTH) && !tx_take) |=> (tx_level == CW'(DEPTH)));

endmodule

// File: tb/uart_fc_core_test.sv
module uart_fc_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_pop = 0, stat_rd = 0, tx_push = 0, ctrl_we = 0;
    logic       rx_strobe = 0, tx_ack = 0, cts = 0;
    logic [7:0] tx_wdata = '0, rx_byte = '0;
    logic [6:0] ctrl_wdata = '0;
    logic [7:0] rx_data, tx_byte;
    logic [5:0] rx_level, tx_level;
    logic       overrun, rx_irq, tx_irq, tx_req, rts;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    uart_fc_core uut (
        .clk(clk), .rst(rst), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_level(rx_level), .stat_rd(stat_rd), .overrun(overrun),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_level(tx_level),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack),
        .cts(cts), .rts(rts)
    );

    // {rx code, tx code, rx threshold, tx threshold}
    localparam logic [13:0] VEC [4] = '{
        {2'd0, 2'd0, 5'd8,  5'd1},
        {2'd1, 2'd1, 5'd16, 5'd4},
        {2'd2, 2'd2, 5'd24, 5'd8},
        {2'd3, 2'd3, 5'd28, 5'd16}
    };

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [6:0] v);
        ctrl_we = 1; ctrl_wdata = v; tick(); ctrl_we = 0;
    endtask

    task automatic rx_in(input logic [7:0] d);
        rx_strobe = 1; rx_byte = d; tick(); rx_strobe = 0;
    endtask

    task automatic rx_take();
        rx_pop = 1; tick(); rx_pop = 0;
    endtask

    task automatic tx_in(input logic [7:0] d);
        tx_push = 1; tx_wdata = d; tick(); tx_push = 0;
    endtask

    task automatic ack();
        tx_ack = 1; tick(); tx_ack = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();

        // reset state
        chk(rx_level, 0, "R1 reset rx_level");
        chk(tx_level, 0, "R9 reset tx_level");
        chk(overrun, 0, "R2 reset overrun");
        chk(rts, 0, "R6 reset rts");
        chk(tx_req, 0, "R8 reset tx_req");
        chk(rx_irq, 0, "R3 reset rx_irq");
        chk(tx_irq, 1, "R4 reset tx_irq");

        // threshold table
        for (int v = 0; v < 4; v++) begin
            int rt;
            int tt;
            rt = int'(VEC[v][9:5]);
            tt = int'(VEC[v][4:0]);
            wr_ctrl({VEC[v][13:12], VEC[v][11:10], 3'b000});
            for (int i = 0; i < rt - 1; i++) rx_in(8'(v * 40 + i));
            chk(rx_irq, 0, "R3 rx_irq below threshold");
            rx_in(8'(v * 40 + rt - 1));
            chk(rx_irq, 1, "R3 rx_irq at threshold");
            chk(rx_level, rt, "R1 rx_level");
            for (int i = 0; i < rt; i++) begin
                chk(rx_data, v * 40 + i, "R1 rx order");
                rx_take();
            end
            chk(rx_level, 0, "R1 rx drained");
            rx_take();
            chk(rx_level, 0, "R1 pop on empty");

            chk(tx_irq, 1, "R4 tx_irq empty");
            for (int i = 0; i < tt; i++) tx_in(8'(v * 50 + i + 3));
            chk(tx_irq, 1, "R4 tx_irq at threshold");
            tx_in(8'(v * 50 + tt + 3));
            chk(tx_irq, 0, "R4 tx_irq above threshold");
            for (int i = 0; i <= tt; i++) begin
                chk(tx_req, 1, "R8 tx_req with data");
                chk(tx_byte, v * 50 + i + 3, "R8 tx order");
                ack();
            end
            chk(tx_level, 0, "R8 tx drained");
        end

        // ack with nothing queued
        ack();
        chk(tx_level, 0, "R8 ack without request");

        // software RTS
        wr_ctrl(7'b0000001);
        chk(rts, 1, "R6 software rts high");
        wr_ctrl(7'b0000000);
        chk(rts, 0, "R6 software rts low");

        // automatic RTS, threshold 8
        wr_ctrl(7'b0000010);
        tick();
        chk(rts, 1, "R5 rts high when empty");
        for (int i = 0; i < 7; i++) rx_in(8'(i));
        tick();
        chk(rts, 1, "R5 rts high below threshold");
        rx_in(8'd7);
        tick();
        chk(rts, 0, "R5 rts low at threshold");
        rx_take();
        tick();
        chk(rts, 0, "R5 rts held in hysteresis band");
        rx_take();
        tick();
        chk(rts, 1, "R5 rts released");
        for (int i = 0; i < 6; i++) rx_take();
        chk(rx_level, 0, "R1 drained after rts test");

        // overrun
        wr_ctrl(7'b0000000);
        for (int i = 0; i < 32; i++) rx_in(8'(i + 100));
        chk(overrun, 0, "R2 no overrun when just full");
        rx_in(8'hEE);
        chk(overrun, 1, "R2 overrun set on drop");
        chk(rx_level, 32, "R2 level stays full");
        tick();
        chk(overrun, 1, "R2 overrun sticky");
        stat_rd = 1; tick(); stat_rd = 0;
        chk(overrun, 0, "R2 overrun cleared");
        stat_rd = 1; rx_strobe = 1; rx_byte = 8'hDD; tick();
        stat_rd = 0; rx_strobe = 0;
        chk(overrun, 1, "R2 drop wins over clear");
        stat_rd = 1; tick(); stat_rd = 0;
        for (int i = 0; i < 32; i++) begin
            chk(rx_data, i + 100, "R2 dropped bytes absent");
            rx_take();
        end

        // automatic CTS
        wr_ctrl(7'b0000100);
        cts = 0;
        tx_in(8'hA0); tx_in(8'hA1); tx_in(8'hA2);
        repeat (3) tick();
        chk(tx_req, 0, "R7 blocked by cts");
        ack();
        chk(tx_level, 3, "R7 bytes held");
        cts = 1;
        repeat (3) tick();
        chk(tx_req, 1, "R7 released by cts");
        chk(tx_byte, 8'hA0, "R7 head byte");
        ack();
        chk(tx_level, 2, "R7 one byte sent");
        cts = 0;
        repeat (3) tick();
        chk(tx_req, 0, "R7 blocked again");
        ack();
        chk(tx_level, 2, "R7 held with data queued");
        chk(tx_byte, 8'hA1, "R7 head unchanged");
        wr_ctrl(7'b0000000);
        chk(tx_req, 1, "R10 cts ignored when auto off");
        ack(); ack();
        chk(tx_level, 0, "R10 drained with cts low");

        // transmit full
        for (int i = 0; i < 33; i++) tx_in(8'(i));
        chk(tx_level, 32, "R9 push ignored when full");
        for (int i = 0; i < 32; i++) begin
            chk(tx_byte, i, "R9 order after full push");
            ack();
        end
        chk(tx_level, 0, "R9 drained");

        done = 1;
        finish_run();
    end

endmodule